// File: doc/BRIEF.md
# GPIO Configuration Register Bank

This block holds the configuration of a bank of general-purpose pins (95 by default) and presents it on a plain 32-bit register port. Every pin owns two configuration words. The first carries the mode select, the direction, the synchronized input level and the output level. The second carries the weak-pull code and a switch that turns input sensing off. Two shared bitmap areas sit at the bottom of the address map: an ownership bitmap that marks which pins firmware has kept for itself, and an interrupt-routing word whose bits steer a fixed subset of pins to a direct interrupt path. Both are plain storage and are fanned out as per-pin vectors.

The pad side is driven straight from the stored fields: output level, output enable, pull code and sense-disable go to the pad ring. The pad input passes through a two-stage synchronizer and is gated by the sense switch before it is seen on the register port or on the per-pin input vector that downstream interrupt logic uses. Register access takes one cycle: a write takes effect at the clock edge where it is presented, and read data appears on the next cycle and holds until the next read.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After reset every pin's first word reads 0x0000_0005 (mode = GPIO code 1 in bits 1:0, direction = input with bit 2 = 1, output level 0) and its second word reads 0x0000_0004 (sensing off, pull 0). All pad outputs are low except pad_sense_dis, which is all ones; own_map and route_en are all zero.
- R2: Pin p's first word is at byte address 0x100 + 8·p and its second word at 0x104 + 8·p. Bit 31 of the first word drives pad_out[p] and reads back.
- R3: When bit 2 of the second word is set, bit 30 of the first word reads 0 and pin_in_sync[p] is 0 whatever the pad does.
- R4: With sensing on, pad_in[p] appears on pin_in_sync[p] and in bit 30 of the first word two clock edges after it is applied (two-flop synchronizer).
- R5: pad_oe[p] is 1 only while the mode field (bits 1:0) is 1 and the direction bit (bit 2) is 0; other mode codes or direction 1 give 0.
- R6: Bits 1:0 of the second word drive pad_pull[2p+1:2p] (0 none, 1 down, 2 up) and bit 2 drives pad_sense_dis[p]; both read back.
- R7: The ownership bitmap occupies word k at 0x00 + 4·k with bit (p mod 32) for pin p = 32·k + (p mod 32), driving own_map[p] (0 = kept by firmware). Bits of pins at or above NPIN ignore writes and read 0.
- R8: The routing word at 0x10 keeps bits 15:0; bits 0–2 steer pins 8–10, bits 3–4 pins 13–14 and bits 5–15 pins 45–55 onto route_en. Every other pin's route_en is 0 and bits 31:16 read 0.
- R9: Bit 30 and the unused bits of both configuration words ignore writes and read 0. Addresses that are not word aligned or that map to no register read 0, and writes to them change nothing.
- R10: bus_rdata is loaded on the cycle after a read strobe (bus_sel = 1, bus_wr = 0) and keeps its value during writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| pad_in | input | NPIN | Raw pad input levels |
| pad_out | output | NPIN | Output level per pad |
| pad_oe | output | NPIN | Output enable per pad |
| pad_pull | output | 2*NPIN | Weak-pull code, two bits per pin |
| pad_sense_dis | output | NPIN | Input sensing off per pin |
| pin_in_sync | output | NPIN | Synchronized, sense-gated input level |
| own_map | output | NPIN | Ownership bit per pin |
| route_en | output | NPIN | Direct interrupt routing per pin |

## Verification
The bench aims at the pins at the edges of the map: pin 94, whose words sit last, the partial third ownership word, where a design that stores the high bits would read 0xFFFF_FFFF instead of 0x7FFF_FFFF, and the address just past the last pin, which a loose decoder would alias onto pin 0. It measures the synchronizer latency edge by edge, so a design with one stage or three is caught, and it turns sensing off on a pin driven high, which a design that gates only the register bit and not the vector would miss. It writes all-ones to the routing word and checks that pins 11, 12 and 44 stay unrouted, and it sends a misaligned write to show that such a design would corrupt a neighbouring pin. Random writes to random pins against a shadow model cover the rest.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int CFG_BASE   = 'h100;
  localparam int ROUTE_BASE = 'h10;
  localparam int ROUTE_BITS = 16;

  localparam int A_OUT = 31;
  localparam int A_IN  = 30;
  localparam int A_DIR = 2;
  localparam int B_DIS = 2;

  typedef enum logic [1:0] {
    USE_NATIVE = 2'd0,
    USE_GPIO   = 2'd1,
    USE_ALT2   = 2'd2,
    USE_ALT3   = 2'd3
  } use_sel_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2,
    PULL_RSVD = 2'd3
  } pull_e;

  // Routing-word bit that steers pin p, or -1 when the pin has none.
  function automatic int route_slot(int p);
    if (p >= 8 && p <= 10)  return p - 8;
    if (p >= 13 && p <= 14) return p - 10;
    if (p >= 45 && p <= 55) return p - 40;
    return -1;
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int NPIN   = 95,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]             addr,
  output logic                          pin_hit,
  output logic [$clog2(NPIN)-1:0]       pin_idx,
  output logic                          pin_hi,
  output logic                          own_hit,
  output logic [((NPIN+31)/32 > 1 ? $clog2((NPIN+31)/32) : 1)-1:0] own_idx,
  output logic                          route_hit
);
  localparam int PIN_W = $clog2(NPIN);
  localparam int NW    = (NPIN + 31) / 32;
  localparam int OWN_W = (NW > 1) ? $clog2(NW) : 1;
  localparam int SW    = ADDR_W - 3;
  localparam int WW    = ADDR_W - 2;

  logic              aligned;
  logic [SW-1:0]     pin_sel;
  logic [WW-1:0]     word_idx;

  assign aligned  = (addr[1:0] == 2'b00);
  assign pin_sel  = addr[ADDR_W-1:3] - SW'(CFG_BASE >> 3);
  assign word_idx = addr[ADDR_W-1:2];

  assign pin_hit   = aligned && (addr >= ADDR_W'(CFG_BASE)) && (pin_sel < SW'(NPIN));
  assign pin_idx   = pin_sel[PIN_W-1:0];
  assign pin_hi    = addr[2];
  assign own_hit   = aligned && (word_idx < WW'(NW));
  assign own_idx   = word_idx[OWN_W-1:0];
  assign route_hit = aligned && (word_idx == WW'(ROUTE_BASE >> 2));

endmodule

// File: rtl/gpio_bitmaps.sv
module gpio_bitmaps
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 95
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  own_we,
  input  logic [((NPIN+31)/32 > 1 ? $clog2((NPIN+31)/32) : 1)-1:0] own_idx,
  input  logic                  route_we,
  input  logic [31:0]           wdata,
  output logic [NPIN-1:0]       own_map,
  output logic [31:0]           own_rd,
  output logic [ROUTE_BITS-1:0] route_rd,
  output logic [NPIN-1:0]       route_en
);
  localparam int NW    = (NPIN + 31) / 32;
  localparam int OWN_W = (NW > 1) ? $clog2(NW) : 1;
  localparam int PADW  = (1 << OWN_W) * 32;

  logic [NPIN-1:0]       own_q;
  logic [NPIN-1:0]       wmask;
  logic [NPIN-1:0]       wpat;
  logic [NW-1:0]         word_sel;
  logic [PADW-1:0]       own_pad;
  logic [ROUTE_BITS-1:0] route_q;

  assign word_sel = own_we ? (NW'(1) << own_idx) : '0;

  for (genvar p = 0; p < NPIN; p++) begin : g_own
    assign wmask[p] = word_sel[p / 32];
    assign wpat[p]  = wdata[p % 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= '0;
      route_q <= '0;
    end else begin
      own_q <= (own_q & ~wmask) | (wpat & wmask);
      if (route_we) route_q <= wdata[ROUTE_BITS-1:0];
    end
  end

  assign own_pad  = PADW'(own_q);
  assign own_rd   = own_pad[{own_idx, 5'b0} +: 32];
  assign own_map  = own_q;
  assign route_rd = route_q;

  for (genvar p = 0; p < NPIN; p++) begin : g_route
    localparam int SLOT = route_slot(p);
    if (SLOT >= 0) begin : g_on
      assign route_en[p] = route_q[SLOT];
    end else begin : g_off
      assign route_en[p] = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_a,
  input  logic        we_b,
  input  logic        w_out,
  input  logic        w_dir,
  input  logic [1:0]  w_use,
  input  logic        w_dis,
  input  logic [1:0]  w_pull,
  input  logic        pad_in,
  output logic        pad_out,
  output logic        pad_oe,
  output logic [1:0]  pad_pull,
  output logic        sense_dis,
  output logic        in_sync,
  output logic [31:0] word_a,
  output logic [31:0] word_b
);
  logic     out_q;
  logic     dir_q;
  use_sel_e use_q;
  logic     dis_q;
  pull_e    pull_q;
  logic     s1_q;
  logic     s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      dir_q  <= 1'b1;
      use_q  <= USE_GPIO;
      dis_q  <= 1'b1;
      pull_q <= PULL_NONE;
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
    end else begin
      s1_q <= pad_in;
      s2_q <= s1_q;
      if (we_a) begin
        out_q <= w_out;
        dir_q <= w_dir;
        use_q <= use_sel_e'(w_use);
      end
      if (we_b) begin
        dis_q  <= w_dis;
        pull_q <= pull_e'(w_pull);
      end
    end
  end

  assign in_sync   = s2_q & ~dis_q;
  assign pad_out   = out_q;
  assign pad_oe    = (use_q == USE_GPIO) && !dir_q;
  assign pad_pull  = pull_q;
  assign sense_dis = dis_q;

  always_comb begin
    word_a        = '0;
    word_a[A_OUT] = out_q;
    word_a[A_IN]  = in_sync;
    word_a[A_DIR] = dir_q;
    word_a[1:0]   = use_q;
    word_b        = '0;
    word_b[B_DIS] = dis_q;
    word_b[1:0]   = pull_q;
  end

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPIN   = 95,
  parameter int ADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NPIN-1:0]    pad_in,
  output logic [NPIN-1:0]    pad_out,
  output logic [NPIN-1:0]    pad_oe,
  output logic [2*NPIN-1:0]  pad_pull,
  output logic [NPIN-1:0]    pad_sense_dis,
  output logic [NPIN-1:0]    pin_in_sync,
  output logic [NPIN-1:0]    own_map,
  output logic [NPIN-1:0]    route_en
);
  localparam int PIN_W = $clog2(NPIN);
  localparam int NW    = (NPIN + 31) / 32;
  localparam int OWN_W = (NW > 1) ? $clog2(NW) : 1;

  logic                  pin_hit, pin_hi, own_hit, route_hit;
  logic [PIN_W-1:0]      pin_idx;
  logic [OWN_W-1:0]      own_idx;
  logic                  wr_go, rd_go;
  logic [31:0]           own_rd;
  logic [ROUTE_BITS-1:0] route_rd;
  logic [31:0]           word_a [NPIN];
  logic [31:0]           word_b [NPIN];
  logic [31:0]           rd_val;

  assign wr_go = bus_sel && bus_wr;
  assign rd_go = bus_sel && !bus_wr;

  gpio_addr_dec #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_dec (
    .addr      (bus_addr),
    .pin_hit   (pin_hit),
    .pin_idx   (pin_idx),
    .pin_hi    (pin_hi),
    .own_hit   (own_hit),
    .own_idx   (own_idx),
    .route_hit (route_hit)
  );

  gpio_bitmaps #(.NPIN(NPIN)) u_maps (
    .clk      (clk),
    .rst_n    (rst_n),
    .own_we   (wr_go && own_hit),
    .own_idx  (own_idx),
    .route_we (wr_go && route_hit),
    .wdata    (bus_wdata),
    .own_map  (own_map),
    .own_rd   (own_rd),
    .route_rd (route_rd),
    .route_en (route_en)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic sel;
    assign sel = wr_go && pin_hit && (pin_idx == PIN_W'(p));
    gpio_pin_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_a      (sel && !pin_hi),
      .we_b      (sel && pin_hi),
      .w_out     (bus_wdata[A_OUT]),
      .w_dir     (bus_wdata[A_DIR]),
      .w_use     (bus_wdata[1:0]),
      .w_dis     (bus_wdata[B_DIS]),
      .w_pull    (bus_wdata[1:0]),
      .pad_in    (pad_in[p]),
      .pad_out   (pad_out[p]),
      .pad_oe    (pad_oe[p]),
      .pad_pull  (pad_pull[2*p +: 2]),
      .sense_dis (pad_sense_dis[p]),
      .in_sync   (pin_in_sync[p]),
      .word_a    (word_a[p]),
      .word_b    (word_b[p])
    );
  end

  always_comb begin
    rd_val = '0;
    if (pin_hit)        rd_val = pin_hi ? word_b[pin_idx] : word_a[pin_idx];
    else if (own_hit)   rd_val = own_rd;
    else if (route_hit) rd_val = 32'(route_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_go) bus_rdata <= rd_val;
  end

endmodule

// File: rtl/gpio_cfg_bank_chk.sv
module gpio_cfg_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPIN   = 95,
  parameter int ADDR_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [NPIN-1:0]    pad_in,
  input logic [NPIN-1:0]    pad_out,
  input logic [NPIN-1:0]    pad_oe,
  input logic [2*NPIN-1:0]  pad_pull,
  input logic [NPIN-1:0]    pad_sense_dis,
  input logic [NPIN-1:0]    pin_in_sync,
  input logic [NPIN-1:0]    own_map,
  input logic [NPIN-1:0]    route_en
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R3: a pin with sensing off never shows an input level
  a_r3_gated_input: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_in_sync & pad_sense_dis) == '0);

  // R4: two-stage latency from pad to synchronized vector
  a_r4_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (pin_in_sync == ($past(pad_in, 2) & ~pad_sense_dis)));

  // R5: output enable follows the mode and direction written to pin 0
  a_r5_oe_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(CFG_BASE)) |=>
      (pad_oe[0] == ($past(bus_wdata[1:0]) == 2'd1 && !$past(bus_wdata[2]))));

  // R9: unused bits of a first configuration word read as zero
  a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(CFG_BASE)) |=> (bus_rdata[29:3] == '0));

  // R10: read data holds unless a read is strobed
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

  // R2: stored pad controls only move on a write
  a_r2_no_spurious_change: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_pull) &&
                              $stable(pad_sense_dis) && $stable(own_map) && $stable(route_en)));

endmodule

bind gpio_cfg_bank gpio_cfg_bank_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_sel       (bus_sel),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .pad_in        (pad_in),
  .pad_out       (pad_out),
  .pad_oe        (pad_oe),
  .pad_pull      (pad_pull),
  .pad_sense_dis (pad_sense_dis),
  .pin_in_sync   (pin_in_sync),
  .own_map       (own_map),
  .route_en      (route_en)
);

// File: tb/sim_gpio_cfg_bank.sv
`timescale 1ns/1ps
module sim_gpio_cfg_bank;
  localparam int NP = 95;
  localparam int AW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0;
  logic            bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NP-1:0]   pad_in = '0;
  logic [NP-1:0]   pad_out, pad_oe, pad_sense_dis, pin_in_sync, own_map, route_en;
  logic [2*NP-1:0] pad_pull;

  always #4 clk = ~clk;

  gpio_cfg_bank #(.NPIN(NP), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
    .pad_sense_dis(pad_sense_dis), .pin_in_sync(pin_in_sync),
    .own_map(own_map), .route_en(route_en)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // shadow model
  bit       m_out [NP];
  bit       m_dir [NP];
  bit [1:0] m_use [NP];
  bit       m_dis [NP];
  bit [1:0] m_pull[NP];
  bit [NP-1:0] m_own;
  bit [15:0]   m_route;

  function automatic int slot_of(int p);
    if (p >= 8 && p <= 10)  return p - 8;
    if (p >= 13 && p <= 14) return p - 10;
    if (p >= 45 && p <= 55) return p - 40;
    return -1;
  endfunction

  function automatic logic [31:0] exp_a(int p);
    logic [31:0] v = '0;
    v[31]  = m_out[p];
    v[30]  = m_dis[p] ? 1'b0 : pad_in[p];
    v[2]   = m_dir[p];
    v[1:0] = m_use[p];
    return v;
  endfunction

  function automatic logic [31:0] exp_b(int p);
    return {29'b0, m_dis[p], m_pull[p]};
  endfunction

  function automatic logic [NP-1:0] exp_sync();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = pad_in[p] & ~m_dis[p];
    return v;
  endfunction

  function automatic logic [NP-1:0] exp_route();
    logic [NP-1:0] v = '0;
    for (int p = 0; p < NP; p++) if (slot_of(p) >= 0) v[p] = m_route[slot_of(p)];
    return v;
  endfunction

  function automatic logic [NP-1:0] exp_dis();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = m_dis[p];
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [AW-1:0] addr_a(int p); return AW'(32'h100 + 8*p); endfunction
  function automatic logic [AW-1:0] addr_b(int p); return AW'(32'h104 + 8*p); endfunction

  task automatic model_a(int p, logic [31:0] d);
    m_out[p] = d[31]; m_dir[p] = d[2]; m_use[p] = d[1:0];
  endtask

  task automatic model_b(int p, logic [31:0] d);
    m_dis[p] = d[2]; m_pull[p] = d[1:0];
  endtask

  task automatic pin_check(int p, string req);
    logic [31:0] r;
    rd(addr_a(p), r); check(r === exp_a(p), req, r, exp_a(p));
    rd(addr_b(p), r); check(r === exp_b(p), req, r, exp_b(p));
    check(pad_out[p] === m_out[p], req, pad_out[p], m_out[p]);
    check(pad_oe[p] === (m_use[p] == 2'd1 && !m_dir[p]), "R5", pad_oe[p],
          (m_use[p] == 2'd1 && !m_dir[p]));
    check(pad_pull[2*p +: 2] === m_pull[p], "R6", pad_pull[2*p +: 2], m_pull[p]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, held;
    void'($urandom(32'd4242));
    for (int p = 0; p < NP; p++) begin
      m_out[p] = 0; m_dir[p] = 1; m_use[p] = 2'd1; m_dis[p] = 1; m_pull[p] = 0;
    end
    m_own = '0; m_route = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(addr_a(0), r);  check(r === 32'h5, "R1", r, 32'h5);
    rd(addr_b(94), r); check(r === 32'h4, "R1", r, 32'h4);
    rd(addr_a(94), r); check(r === 32'h5, "R1", r, 32'h5);
    check(pad_oe === '0 && pad_out === '0 && pad_pull === '0, "R1", pad_oe, 0);
    check(pad_sense_dis === '1, "R1", pad_sense_dis, {NP{1'b1}});
    check(own_map === '0 && route_en === '0, "R1", own_map, 0);

    // R2: last pin output level via its own address
    wr(addr_a(94), 32'h8000_0005); model_a(94, 32'h8000_0005);
    check(pad_out[94] === 1'b1 && pad_out[93:0] === '0, "R2", pad_out, {1'b1, 94'b0});
    pin_check(94, "R2");

    // R4: synchronizer latency, edge by edge, on pin 5
    wr(addr_b(5), 32'h0); model_b(5, 32'h0);
    @(negedge clk); pad_in[5] = 1'b1;
    @(negedge clk); check(pin_in_sync[5] === 1'b0, "R4", pin_in_sync[5], 0);
    @(negedge clk); check(pin_in_sync[5] === 1'b1, "R4", pin_in_sync[5], 1);
    rd(addr_a(5), r); check(r[30] === 1'b1, "R4", r, 32'h4000_0005);

    // R3: sensing off hides a high pad
    wr(addr_b(5), 32'h4); model_b(5, 32'h4);
    check(pin_in_sync[5] === 1'b0, "R3", pin_in_sync[5], 0);
    rd(addr_a(5), r); check(r[30] === 1'b0, "R3", r, 32'h5);

    // R5: mode and direction combinations
    wr(addr_a(7), 32'h0); model_a(7, 32'h0);
    check(pad_oe[7] === 1'b0, "R5", pad_oe[7], 0);
    wr(addr_a(7), 32'h1); model_a(7, 32'h1);
    check(pad_oe[7] === 1'b1, "R5", pad_oe[7], 1);
    wr(addr_a(7), 32'h2); model_a(7, 32'h2);
    check(pad_oe[7] === 1'b0, "R5", pad_oe[7], 0);
    wr(addr_a(7), 32'h5); model_a(7, 32'h5);
    check(pad_oe[7] === 1'b0, "R5", pad_oe[7], 0);

    // R6: pull codes
    wr(addr_b(20), 32'h2); model_b(20, 32'h2);
    check(pad_pull[41:40] === 2'd2 && pad_sense_dis[20] === 1'b0, "R6", pad_pull[41:40], 2);
    pin_check(20, "R6");

    // R7: partial ownership word
    wr(AW'(32'h08), 32'hFFFF_FFFF); m_own[94:64] = '1;
    rd(AW'(32'h08), r); check(r === 32'h7FFF_FFFF, "R7", r, 32'h7FFF_FFFF);
    check(own_map === m_own, "R7", own_map, m_own);
    wr(AW'(32'h00), 32'hA5A5_0001); m_own[31:0] = 32'hA5A5_0001;
    rd(AW'(32'h00), r); check(r === 32'hA5A5_0001, "R7", r, 32'hA5A5_0001);
    check(own_map === m_own, "R7", own_map, m_own);

    // R8: routing word and its pin map
    wr(AW'(32'h10), 32'hFFFF_FFFF); m_route = 16'hFFFF;
    rd(AW'(32'h10), r); check(r === 32'h0000_FFFF, "R8", r, 32'hFFFF);
    check(route_en === exp_route(), "R8", route_en, exp_route());
    check(route_en[11] === 1'b0 && route_en[12] === 1'b0 && route_en[44] === 1'b0 &&
          route_en[56] === 1'b0, "R8", route_en, exp_route());
    wr(AW'(32'h10), 32'h0000_0021); m_route = 16'h0021;
    check(route_en === exp_route(), "R8", route_en, exp_route());

    // R9: read-only and unused bits, unmapped and misaligned addresses
    wr(addr_a(3), 32'hFFFF_FFFF); model_a(3, 32'hFFFF_FFFF);
    rd(addr_a(3), r); check(r === exp_a(3), "R9", r, exp_a(3));
    wr(addr_b(3), 32'hFFFF_FFFB); model_b(3, 32'hFFFF_FFFB);
    rd(addr_b(3), r); check(r === 32'h3, "R9", r, 32'h3);
    wr(AW'(32'h101), 32'h8000_0000);
    rd(addr_a(0), r); check(r === exp_a(0), "R9", r, exp_a(0));
    rd(AW'(32'h101), r); check(r === 32'h0, "R9", r, 0);
    wr(AW'(32'h3F8), 32'hFFFF_FFFF);
    rd(AW'(32'h3F8), r); check(r === 32'h0, "R9", r, 0);
    rd(addr_a(0), r); check(r === exp_a(0), "R9", r, exp_a(0));
    rd(AW'(32'h0C), r); check(r === 32'h0, "R9", r, 0);
    check(pad_out === {1'b1, 90'b0, 1'b1, 3'b0}, "R9", pad_out, {1'b1, 90'b0, 1'b1, 3'b0});

    // R10: read data holds across writes and idle cycles
    rd(AW'(32'h10), held);
    wr(addr_a(30), 32'h8000_0001); model_a(30, 32'h8000_0001);
    repeat (3) @(negedge clk);
    check(bus_rdata === held, "R10", bus_rdata, held);

    // random phase
    for (int it = 0; it < 300; it++) begin
      int p;
      logic [31:0] d;
      p = int'($urandom_range(NP - 1, 0));
      d = $urandom();
      if (it % 10 == 0) begin
        pad_in = NP'({$urandom(), $urandom(), $urandom()});
        repeat (3) @(negedge clk);
      end
      if ($urandom_range(1, 0) == 0) begin
        wr(addr_a(p), d); model_a(p, d);
      end else begin
        wr(addr_b(p), d); model_b(p, d);
      end
      pin_check(p, "R2");
      check(pin_in_sync === exp_sync(), "R4", pin_in_sync, exp_sync());
      check(pad_sense_dis === exp_dis(), "R6", pad_sense_dis, exp_dis());
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule